// File: doc/BRIEF.md
# Masked Exclusive Prefix Count Unit

This unit takes a source mask and writes, into every active element of a destination register group, how many active source bits are set at strictly lower element indices. It is an exclusive running count: an element's own source bit only affects elements above it. A governing mask, turned on by an enable, decides which elements take part. An element switched off by that mask keeps its old destination contents and does not add to the count.

Elements are SEW bits wide, and SEW is chosen at run time from 8, 16, 32 or 64. The number of elements is the vector length times the group multiplier, divided by SEW. Elements at and above that count pass through unchanged. The operation is refused when the destination register index equals the source index, when the start index is nonzero, or when masking is on and the destination is register 0. A refused operation leaves the destination unchanged and raises a flag.

With default parameters the vector length is 128 bits and the multiplier goes up to 8, so the group is 1024 bits and holds at most 128 elements. The result appears one cycle after the request.

Top module: `pfx_cnt_unit`

## Requirements
- R1: An active element i receives the number of active elements j<i whose source bit is set. Active element 0 receives 0, and an element's own source bit is not part of its own value.
- R2: When mask_en_i=1, an element whose gov_mask_i bit is 0 is inactive. It keeps its old_dest_i contents and does not advance the count. When mask_en_i=0, every element below the element count is active.
- R3: The element count is n = VLEN * 2^lmul_exp_i / SEW, with lmul_exp_i 0..3 meaning 1, 2, 4 and 8. Elements with index >= n keep their old contents, and source bits at index >= n are not counted.
- R4: sew_i selects the element width: 0 means 8, 1 means 16, 2 means 32 and 3 means 64 bits. Element i occupies result_o[i*SEW +: SEW], and the count is truncated or zero-extended to SEW bits. With the defaults the largest count is 127, at SEW=8 with LMUL=8.
- R5: illegal_o is 1 for a request in any of these cases: vd_idx_i equals vs2_idx_i, vstart_i is nonzero, or mask_en_i=1 with vd_idx_i=0. In that case result_o equals old_dest_i and vstart_clr_o is 0.
- R6: valid_o is 1 exactly one cycle after valid_i is 1, and result_o and illegal_o are updated only then. After a cycle with valid_i=0, valid_o is 0 and result_o holds its value.
- R7: vstart_clr_o is 1 together with valid_o for a legal operation. It is the request to reset the start index to zero.
- R8: While rst_ni is low, valid_o, illegal_o, vstart_clr_o and result_o are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Request strobe |
| src_mask_i | input | 128 | Source mask, one bit per element |
| gov_mask_i | input | 128 | Governing mask, one bit per element |
| mask_en_i | input | 1 | Enables the governing mask |
| old_dest_i | input | 1024 | Current contents of the destination group |
| sew_i | input | 2 | Element width code |
| lmul_exp_i | input | 2 | Group multiplier exponent |
| vd_idx_i | input | 5 | Destination register index |
| vs2_idx_i | input | 5 | Source register index |
| vstart_i | input | 7 | Start element index |
| valid_o | output | 1 | Result strobe |
| result_o | output | 1024 | Packed destination group |
| illegal_o | output | 1 | Request was refused |
| vstart_clr_o | output | 1 | Reset the start index |

## Verification
A fixed table drives dense, alternating, sparse and empty source masks, with and without the governing mask, across every width and multiplier. Dense masks show whether the count is exclusive and ripples across block boundaries. Alternating governing masks show whether inactive elements are skipped instead of counted. Random masks at each width, checked against a loop model, separate faults in packing and truncation. Directed cases cover the smallest group (two elements, where tail pass-through is easy to see), the largest count of 127 in the top byte, and each of the three refusal conditions.

// File: rtl/pfx_cnt_pkg.sv
package pfx_cnt_pkg;
  localparam int VLEN         = 128;
  localparam int LMUL_EXP_MAX = 3;
  localparam int REG_IDX_W    = 5;

  typedef enum logic [1:0] {
    SEW_8  = 2'd0,
    SEW_16 = 2'd1,
    SEW_32 = 2'd2,
    SEW_64 = 2'd3
  } sew_e;
endpackage

// File: rtl/pfx_cnt_elem_ctl.sv
module pfx_cnt_elem_ctl #(
  parameter int VLEN      = 128,
  parameter int MAX_ELEMS = 128,
  parameter int VST_W     = 7,
  parameter int LE_W      = 2,
  parameter int IDX_W     = 5
) (
  input  logic [MAX_ELEMS-1:0] src_i,
  input  logic [MAX_ELEMS-1:0] gov_i,
  input  logic                 mask_en_i,
  input  logic [1:0]           sew_i,
  input  logic [LE_W-1:0]      lmul_exp_i,
  input  logic [IDX_W-1:0]     vd_idx_i,
  input  logic [IDX_W-1:0]     vs2_idx_i,
  input  logic [VST_W-1:0]     vstart_i,
  output logic [MAX_ELEMS-1:0] active_o,
  output logic [MAX_ELEMS-1:0] count_bits_o,
  output logic                 illegal_o
);
  logic [31:0]          grp_bits;
  logic [31:0]          n_elems;
  logic [MAX_ELEMS-1:0] in_rng;

  always_comb begin
    grp_bits = 32'(VLEN) << lmul_exp_i;
    n_elems  = grp_bits >> (32'd3 + 32'(sew_i));
  end

  for (genvar i = 0; i < MAX_ELEMS; i++) begin : g_rng
    assign in_rng[i] = (32'(i) < n_elems);
  end

  assign active_o     = in_rng & (~{MAX_ELEMS{mask_en_i}} | gov_i);
  assign count_bits_o = active_o & src_i;

  assign illegal_o = (vd_idx_i == vs2_idx_i)
                   | (|vstart_i)
                   | (mask_en_i & (vd_idx_i == '0));
endmodule

// File: rtl/pfx_cnt_prefix.sv
module pfx_cnt_prefix #(
  parameter int N   = 128,
  parameter int CW  = 8,
  parameter int BLK = 8,
  localparam int NBLK = N / BLK
) (
  input  logic [N-1:0]    bits_i,
  output logic [N*CW-1:0] cnt_o
);
  // block bases ripple across NBLK blocks; offsets ripple within a block
  logic [CW-1:0] base [NBLK];

  assign base[0] = '0;

  for (genvar b = 0; b < NBLK; b++) begin : g_blk
    logic [CW-1:0] loc [BLK];
    assign loc[0] = '0;
    for (genvar k = 1; k < BLK; k++) begin : g_loc
      assign loc[k] = loc[k-1] + CW'(bits_i[b*BLK+k-1]);
    end
    for (genvar k = 0; k < BLK; k++) begin : g_out
      assign cnt_o[(b*BLK+k)*CW +: CW] = base[b] + loc[k];
    end
    if (b < NBLK - 1) begin : g_next
      assign base[b+1] = base[b] + loc[BLK-1] + CW'(bits_i[b*BLK+BLK-1]);
    end
  end
endmodule

// File: rtl/pfx_cnt_pack.sv
module pfx_cnt_pack #(
  parameter int GRP_W     = 1024,
  parameter int MAX_ELEMS = 128,
  parameter int CW        = 8
) (
  input  logic [MAX_ELEMS*CW-1:0] cnt_i,
  input  logic [MAX_ELEMS-1:0]    active_i,
  input  logic [GRP_W-1:0]        old_i,
  input  logic [1:0]              sew_i,
  output logic [GRP_W-1:0]        res_o
);
  logic [GRP_W-1:0] cand [4];

  for (genvar s = 0; s < 4; s++) begin : g_sew
    localparam int W  = 8 << s;
    localparam int NE = GRP_W / W;
    for (genvar e = 0; e < NE; e++) begin : g_el
      assign cand[s][e*W +: W] = active_i[e] ? W'(cnt_i[e*CW +: CW]) : old_i[e*W +: W];
    end
  end

  assign res_o = cand[sew_i];
endmodule

// File: rtl/pfx_cnt_unit.sv
module pfx_cnt_unit
  import pfx_cnt_pkg::*;
#(
  parameter int VLEN_P       = pfx_cnt_pkg::VLEN,
  parameter int LMUL_EXP_MAX = pfx_cnt_pkg::LMUL_EXP_MAX,
  parameter int BLK          = 8,
  localparam int GRP_W     = VLEN_P << LMUL_EXP_MAX,
  localparam int MAX_ELEMS = GRP_W / 8,
  localparam int CNT_W     = $clog2(MAX_ELEMS + 1),
  localparam int VST_W     = $clog2(MAX_ELEMS),
  localparam int LE_W      = $clog2(LMUL_EXP_MAX + 1)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 valid_i,
  input  logic [MAX_ELEMS-1:0] src_mask_i,
  input  logic [MAX_ELEMS-1:0] gov_mask_i,
  input  logic                 mask_en_i,
  input  logic [GRP_W-1:0]     old_dest_i,
  input  logic [1:0]           sew_i,
  input  logic [LE_W-1:0]      lmul_exp_i,
  input  logic [REG_IDX_W-1:0] vd_idx_i,
  input  logic [REG_IDX_W-1:0] vs2_idx_i,
  input  logic [VST_W-1:0]     vstart_i,
  output logic                 valid_o,
  output logic [GRP_W-1:0]     result_o,
  output logic                 illegal_o,
  output logic                 vstart_clr_o
);
  logic [MAX_ELEMS-1:0]       active;
  logic [MAX_ELEMS-1:0]       count_bits;
  logic [MAX_ELEMS*CNT_W-1:0] cnt;
  logic [GRP_W-1:0]           packed_res;
  logic                       illegal;

  pfx_cnt_elem_ctl #(
    .VLEN(VLEN_P), .MAX_ELEMS(MAX_ELEMS), .VST_W(VST_W), .LE_W(LE_W), .IDX_W(REG_IDX_W)
  ) u_ctl (
    .src_i(src_mask_i), .gov_i(gov_mask_i), .mask_en_i(mask_en_i),
    .sew_i(sew_i), .lmul_exp_i(lmul_exp_i),
    .vd_idx_i(vd_idx_i), .vs2_idx_i(vs2_idx_i), .vstart_i(vstart_i),
    .active_o(active), .count_bits_o(count_bits), .illegal_o(illegal)
  );

  pfx_cnt_prefix #(.N(MAX_ELEMS), .CW(CNT_W), .BLK(BLK)) u_pfx (
    .bits_i(count_bits), .cnt_o(cnt)
  );

  pfx_cnt_pack #(.GRP_W(GRP_W), .MAX_ELEMS(MAX_ELEMS), .CW(CNT_W)) u_pack (
    .cnt_i(cnt), .active_i(active), .old_i(old_dest_i), .sew_i(sew_i), .res_o(packed_res)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o      <= 1'b0;
      illegal_o    <= 1'b0;
      vstart_clr_o <= 1'b0;
      result_o     <= '0;
    end else begin
      valid_o      <= valid_i;
      vstart_clr_o <= valid_i & ~illegal;
      if (valid_i) begin
        illegal_o <= illegal;
        result_o  <= illegal ? old_dest_i : packed_res;
      end
    end
  end
endmodule

// File: rtl/pfx_cnt_chk.sv
module pfx_cnt_chk #(
  parameter int GRP_W     = 1024,
  parameter int MAX_ELEMS = 128,
  parameter int VST_W     = 7
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 valid_i,
  input logic [MAX_ELEMS-1:0] gov_mask_i,
  input logic                 mask_en_i,
  input logic [GRP_W-1:0]     old_dest_i,
  input logic [4:0]           vd_idx_i,
  input logic [4:0]           vs2_idx_i,
  input logic [VST_W-1:0]     vstart_i,
  input logic                 valid_o,
  input logic [GRP_W-1:0]     result_o,
  input logic                 illegal_o,
  input logic                 vstart_clr_o
);
  logic legal_req;
  assign legal_req = valid_i && (vd_idx_i != vs2_idx_i) && (vstart_i == '0)
                   && !(mask_en_i && (vd_idx_i == '0));

  p_valid_lat_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);
  p_idle_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> (!valid_o && $stable(result_o)));
  p_same_idx_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && vd_idx_i == vs2_idx_i) |=> (illegal_o && !vstart_clr_o && result_o == $past(old_dest_i)));
  p_vstart_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && vstart_i != '0) |=> (illegal_o && result_o == $past(old_dest_i)));
  p_masked_v0_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && mask_en_i && vd_idx_i == '0) |=> illegal_o);
  p_clr_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    legal_req |=> (vstart_clr_o && !illegal_o));
  p_first_zero_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (legal_req && (!mask_en_i || gov_mask_i[0])) |=> (result_o[7:0] == 8'd0));
  p_inactive_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (legal_req && mask_en_i && !gov_mask_i[0]) |=> (result_o[7:0] == $past(old_dest_i[7:0])));
endmodule

bind pfx_cnt_unit pfx_cnt_chk #(.GRP_W(GRP_W), .MAX_ELEMS(MAX_ELEMS), .VST_W(VST_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .gov_mask_i(gov_mask_i),
  .mask_en_i(mask_en_i), .old_dest_i(old_dest_i), .vd_idx_i(vd_idx_i),
  .vs2_idx_i(vs2_idx_i), .vstart_i(vstart_i), .valid_o(valid_o),
  .result_o(result_o), .illegal_o(illegal_o), .vstart_clr_o(vstart_clr_o)
);

// File: tb/sim_pfx_cnt_unit.sv
module sim_pfx_cnt_unit;
  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          valid_i = 1'b0;
  logic [127:0]  src_mask_i = '0;
  logic [127:0]  gov_mask_i = '0;
  logic          mask_en_i = 1'b0;
  logic [1023:0] old_dest_i = '0;
  logic [1:0]    sew_i = '0;
  logic [1:0]    lmul_exp_i = '0;
  logic [4:0]    vd_idx_i = 5'd2;
  logic [4:0]    vs2_idx_i = 5'd3;
  logic [6:0]    vstart_i = '0;
  logic          valid_o;
  logic [1023:0] result_o;
  logic          illegal_o;
  logic          vstart_clr_o;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  always #4 clk_i = ~clk_i;

  pfx_cnt_unit u0 (.*);

  localparam int NT = 8;
  localparam logic [1:0] T_SEW [NT]  = '{2'd0, 2'd1, 2'd2, 2'd3, 2'd0, 2'd1, 2'd2, 2'd3};
  localparam logic [1:0] T_LMUL [NT] = '{2'd0, 2'd1, 2'd2, 2'd3, 2'd3, 2'd2, 2'd1, 2'd0};
  localparam logic       T_MEN [NT]  = '{1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1};
  localparam logic [127:0] T_SRC [NT] = '{
    {4{32'hFFFF_FFFF}}, {4{32'h5555_5555}}, {4{32'hAAAA_AAAA}}, 128'h1 << 5,
    128'h0, {4{32'hF0F0_F0F0}}, {4{32'hFFFF_FFFF}}, {32'h8000_0000, 64'h0, 32'h0000_0001}};
  localparam logic [127:0] T_GOV [NT] = '{
    128'h0, 128'h0, 128'h0, 128'h0,
    {4{32'h3333_3333}}, {4{32'hFFFF_FFFF}}, {4{32'hAAAA_AAAA}}, {4{32'h0F0F_0F0F}}};

  function automatic logic [1023:0] model(input logic [127:0] src, input logic [127:0] gov,
                                          input logic men, input logic [1023:0] old,
                                          input int sew, input int lmul);
    int w = 8 << sew;
    int n = (128 << lmul) >> (3 + sew);
    logic [63:0] c = '0;
    logic [1023:0] r = old;
    for (int i = 0; i < n; i++) begin
      if (!men || gov[i]) begin
        for (int b = 0; b < w; b++) r[i*w+b] = c[b];
        if (src[i]) c = c + 64'd1;
      end
    end
    return r;
  endfunction

  function automatic logic [127:0] rnd128();
    return {$urandom(), $urandom(), $urandom(), $urandom()};
  endfunction

  function automatic logic [1023:0] rnd1024();
    logic [1023:0] v;
    for (int k = 0; k < 32; k++) v[k*32 +: 32] = $urandom();
    return v;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [1023:0] act, input logic [1023:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic run_op(input logic [127:0] src, input logic [127:0] gov, input logic men,
                        input logic [1023:0] old, input logic [1:0] sew, input logic [1:0] lmul,
                        input logic [4:0] vd, input logic [4:0] vs2, input logic [6:0] vst,
                        input string tag);
    bit ill = (vd == vs2) || (vst != 0) || (men && vd == 0);
    logic [1023:0] exp = ill ? old : model(src, gov, men, old, int'(sew), int'(lmul));
    @(negedge clk_i);
    valid_i = 1'b1; src_mask_i = src; gov_mask_i = gov; mask_en_i = men; old_dest_i = old;
    sew_i = sew; lmul_exp_i = lmul; vd_idx_i = vd; vs2_idx_i = vs2; vstart_i = vst;
    @(negedge clk_i);
    valid_i = 1'b0;
    chk(valid_o == 1'b1, "R6 valid", 1024'(valid_o), 1024'(1));
    chk(result_o == exp, tag, result_o, exp);
    chk(illegal_o == ill, "R5 illegal flag", 1024'(illegal_o), 1024'(ill));
    chk(vstart_clr_o == !ill, "R7 vstart clear", 1024'(vstart_clr_o), 1024'(!ill));
  endtask

  initial begin
    repeat (50000) @(posedge clk_i);
    if (!done) begin
      n_err++; n_chk++;
      $display("FAIL watchdog act=0 exp=1");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    logic [1023:0] old;
    logic [1023:0] held;
    repeat (3) @(negedge clk_i);
    chk(valid_o == 0 && illegal_o == 0 && vstart_clr_o == 0 && result_o == '0,
        "R8 reset state", result_o, '0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // table walk (R1 R3 R4)
    for (int t = 0; t < NT; t++) begin
      run_op(T_SRC[t], T_GOV[t], T_MEN[t], rnd1024(), T_SEW[t], T_LMUL[t],
             5'd4, 5'd8, 7'd0, "R1 table result");
    end

    // random masks at every width and multiplier (R4)
    for (int s = 0; s < 4; s++) begin
      for (int l = 0; l < 4; l++) begin
        run_op(rnd128(), rnd128(), 1'($urandom()), rnd1024(), 2'(s), 2'(l),
               5'd1, 5'd9, 7'd0, "R4 random width");
      end
    end

    // R2: even elements active, all source bits set
    old = rnd1024();
    run_op({128{1'b1}}, {64{2'b01}}, 1'b1, old, 2'd0, 2'd0, 5'd5, 5'd6, 7'd0, "R2 gov mask");
    chk(result_o[15:8] == old[15:8], "R2 inactive keeps old", 1024'(result_o[15:8]), 1024'(old[15:8]));
    chk(result_o[23:16] == 8'd1, "R2 inactive not counted", 1024'(result_o[23:16]), 1024'(1));

    // R3: SEW=64, LMUL=1 gives two elements
    old = rnd1024();
    run_op({128{1'b1}}, '0, 1'b0, old, 2'd3, 2'd0, 5'd5, 5'd6, 7'd0, "R3 small group");
    chk(result_o[127:64] == 64'd1, "R3 element one", 1024'(result_o[127:64]), 1024'(1));
    chk(result_o[1023:128] == old[1023:128], "R3 tail unchanged", result_o, old);

    // R4: largest count in the top byte
    run_op({128{1'b1}}, '0, 1'b0, rnd1024(), 2'd0, 2'd3, 5'd5, 5'd6, 7'd0, "R4 max count");
    chk(result_o[1023:1016] == 8'd127, "R4 top element 127", 1024'(result_o[1023:1016]), 1024'(127));

    // R6: idle cycle holds result
    held = result_o;
    @(negedge clk_i);
    chk(valid_o == 1'b0 && result_o == held, "R6 idle hold", result_o, held);

    // R5: refusal cases
    run_op(rnd128(), rnd128(), 1'b0, rnd1024(), 2'd1, 2'd2, 5'd7, 5'd7, 7'd0, "R5 same index");
    run_op(rnd128(), rnd128(), 1'b0, rnd1024(), 2'd0, 2'd1, 5'd7, 5'd3, 7'd5, "R5 vstart nonzero");
    run_op(rnd128(), rnd128(), 1'b1, rnd1024(), 2'd2, 2'd3, 5'd0, 5'd3, 7'd0, "R5 masked v0");
    run_op(rnd128(), rnd128(), 1'b0, rnd1024(), 2'd2, 2'd3, 5'd0, 5'd3, 7'd0, "R5 unmasked v0 legal");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule